// File: doc/BRIEF.md
# Boot Pin Latch and Reset Vector Fetch Sequencer

This block governs the start of execution once reset is released. It counts rising edges of the system clock from the moment reset goes away. On one fixed edge it captures two boot-select pins and turns them into a boot mode and a one-hot memory alias select. Pin activity before or after that edge has no effect on the captured mode.

After the capture it issues two word reads over a simple request/acknowledge port. The first read, at the vector base, loads the initial stack pointer. The second read, one word higher, loads the entry program counter. A done flag then marks the core as free to run.

Entering standby parks the sequencer and drops the done flag. Leaving standby restarts the edge count, recaptures the pins on the same edge count, and repeats both vector reads. A reset at any point restarts the count from zero.

Top module: `boot_seq`

## Requirements
- R1: While reset is held and right after it, boot_mode is 2'b00, alias_sel is 3'b001, fetch_req and seq_done are 0, and stack_ptr and prog_ctr are 0.
- R2: The pins are captured on the 4th rising clock edge after reset release (LATCH_EDGE). After 3 edges boot_mode still holds its earlier value and fetch_req is 0. After the 4th edge boot_mode holds the decoded pins and fetch_req is 1.
- R3: The mode decode is: boot_pin0=0 gives 2'b00 (main flash), boot_pin0=1 with boot_pin1=0 gives 2'b01 (system memory), and both pins at 1 give 2'b10 (SRAM).
- R4: Pin changes between capture events leave boot_mode unchanged.
- R5: The first read requests fetch_addr 0x0000_0000. fetch_data accepted with fetch_ack on that read loads stack_ptr.
- R6: The second read, at 0x0000_0004, is requested only after the first has been acknowledged. Its data loads prog_ctr, and seq_done rises on the same edge. While seq_done is 1, fetch_req is 0.
- R7: fetch_req stays high and fetch_addr stays stable until fetch_ack is seen.
- R8: A standby_enter pulse while done clears seq_done. A later standby_exit pulse restarts the edge count, recaptures the pins on the 4th edge after it, and repeats both reads.
- R9: Reset asserted mid-count restarts the edge count, so the capture happens on the 4th edge after the new release.
- R10: alias_sel is one-hot: bit 0 for main flash, bit 1 for system memory, bit 2 for SRAM, following boot_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| boot_pin0 | input | 1 | Boot select pin 0 |
| boot_pin1 | input | 1 | Boot select pin 1 |
| standby_enter | input | 1 | Strobe: device enters standby |
| standby_exit | input | 1 | Strobe: device leaves standby |
| fetch_req | output | 1 | Vector read request |
| fetch_addr | output | ADDR_W | Vector read address |
| fetch_ack | input | 1 | Read accepted, fetch_data valid |
| fetch_data | input | DATA_W | Read data |
| boot_mode | output | 2 | Captured boot mode |
| alias_sel | output | 3 | One-hot alias select |
| stack_ptr | output | DATA_W | Loaded initial stack pointer |
| prog_ctr | output | DATA_W | Loaded entry program counter |
| seq_done | output | 1 | Both vectors loaded |

## Verification
The assertions take for granted that fetch_ack arrives only while fetch_req is high. They also assume the standby strobes are single-cycle pulses. The stimulus raises acknowledge only after it has seen a request, and it drops acknowledge once the final read is accepted. It pulses each standby strobe for one cycle, and only while the sequence is done (enter) or parked (exit). Pin changes are made both before and after capture edges, so the exact capture point is visible at the ports.

// File: rtl/boot_seq.sv
module boot_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LATCH_EDGE = 4,
  parameter int WORD_BYTES = 4,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_pin0,
  input  logic              boot_pin1,
  input  logic              standby_enter,
  input  logic              standby_exit,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_ack,
  input  logic [DATA_W-1:0] fetch_data,
  output logic [1:0]        boot_mode,
  output logic [2:0]        alias_sel,
  output logic [DATA_W-1:0] stack_ptr,
  output logic [DATA_W-1:0] prog_ctr,
  output logic              seq_done
);
  localparam int CNT_W = $clog2(LATCH_EDGE + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LATCH_EDGE - 1);
  localparam logic [ADDR_W-1:0] PC_ADDR = VEC_BASE + ADDR_W'(WORD_BYTES);

  typedef enum logic [2:0] {S_WAIT, S_SP, S_PC, S_RUN, S_STBY} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       pin_mode;

  assign pin_mode   = !boot_pin0 ? 2'b00 : (boot_pin1 ? 2'b10 : 2'b01);
  assign fetch_req  = (state == S_SP) || (state == S_PC);
  assign fetch_addr = (state == S_PC) ? PC_ADDR : VEC_BASE;
  assign seq_done   = (state == S_RUN);

  always_comb begin
    case (boot_mode)
      2'b01:   alias_sel = 3'b010;
      2'b10:   alias_sel = 3'b100;
      default: alias_sel = 3'b001;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_WAIT;
      cnt       <= '0;
      boot_mode <= 2'b00;
      stack_ptr <= '0;
      prog_ctr  <= '0;
    end else begin
      case (state)
        S_WAIT:
          if (cnt == LAST_CNT) begin
            boot_mode <= pin_mode;
            cnt       <= '0;
            state     <= S_SP;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        S_SP:
          if (fetch_ack) begin
            stack_ptr <= fetch_data;
            state     <= S_PC;
          end
        S_PC:
          if (fetch_ack) begin
            prog_ctr <= fetch_data;
            state    <= S_RUN;
          end
        S_RUN:
          if (standby_enter) state <= S_STBY;
        S_STBY:
          if (standby_exit) begin
            cnt   <= '0;
            state <= S_WAIT;
          end
        default: state <= S_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int WORD_BYTES = 4,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_req,
  input logic              fetch_ack,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [1:0]        boot_mode,
  input logic [2:0]        alias_sel,
  input logic              seq_done
);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !fetch_ack |=> fetch_req && $stable(fetch_addr));
  // R5
  first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_req) |-> fetch_addr == VEC_BASE);
  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !fetch_req);
  // R6
  done_after_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done) |-> $past(fetch_req && fetch_ack &&
                              fetch_addr == VEC_BASE + ADDR_W'(WORD_BYTES)));
  // R4
  mode_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> $stable(boot_mode));
  // R10
  alias_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(alias_sel) == 1);
endmodule

bind boot_seq boot_seq_chk #(
  .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_ack(fetch_ack),
  .fetch_addr(fetch_addr), .boot_mode(boot_mode), .alias_sel(alias_sel),
  .seq_done(seq_done)
);

// File: tb/tb_boot_seq.sv
`timescale 1ns/1ps
module tb_boot_seq;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        boot_pin0 = 0, boot_pin1 = 0;
  logic        standby_enter = 0, standby_exit = 0;
  logic        fetch_ack = 0;
  logic [31:0] fetch_data = '0;
  logic        fetch_req, seq_done;
  logic [31:0] fetch_addr, stack_ptr, prog_ctr;
  logic [1:0]  boot_mode;
  logic [2:0]  alias_sel;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  boot_seq dut (.*);

  // {pin1, pin0, sp, pc, expected mode}
  localparam logic [67:0] VEC [4] = '{
    {2'b00, 32'h2000_1000, 32'h0800_0101, 2'b00},
    {2'b10, 32'h2000_2000, 32'h0800_0201, 2'b00},
    {2'b01, 32'h2000_3000, 32'h1FFF_F001, 2'b01},
    {2'b11, 32'h2000_4000, 32'h2000_0041, 2'b10}
  };

  function automatic logic [2:0] exp_alias(input logic [1:0] m);
    return m == 2'b01 ? 3'b010 : (m == 2'b10 ? 3'b100 : 3'b001);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset();
    rst_n = 0; fetch_ack = 0;
    tick(2);
    rst_n = 1;
  endtask

  task automatic run_fetch(input logic [31:0] sp, input logic [31:0] pc, input string tag);
    chk({tag, " first addr"}, fetch_addr, 32'h0);
    fetch_ack = 1; fetch_data = sp;
    tick();
    chk({tag, " sp"}, stack_ptr, sp);
    chk({tag, " second addr"}, fetch_addr, 32'h4);
    chk({tag, " done low before pc"}, {31'b0, seq_done}, 32'h0);
    fetch_data = pc;
    tick();
    fetch_ack = 0;
    chk({tag, " pc"}, prog_ctr, pc);
    chk({tag, " done"}, {31'b0, seq_done}, 32'h1);
    chk({tag, " req low when done"}, {31'b0, fetch_req}, 32'h0);
  endtask

  initial begin
    rst_n = 0;
    tick(2);
    chk("R1 mode", {30'b0, boot_mode}, 32'h0);
    chk("R1 alias", {29'b0, alias_sel}, 32'h1);
    chk("R1 req/done", {30'b0, fetch_req, seq_done}, 32'h0);
    chk("R1 sp/pc", stack_ptr | prog_ctr, 32'h0);

    for (int v = 0; v < 4; v++) begin
      do_reset();
      {boot_pin1, boot_pin0} = VEC[v][67:66];
      tick(3);
      chk("R2 not yet latched", {29'b0, fetch_req, boot_mode}, 32'h0);
      tick();
      chk("R2 R3 mode", {30'b0, boot_mode}, {30'b0, VEC[v][1:0]});
      chk("R10 alias", {29'b0, alias_sel}, {29'b0, exp_alias(VEC[v][1:0])});
      chk("R2 req", {31'b0, fetch_req}, 32'h1);
      run_fetch(VEC[v][65:34], VEC[v][33:2], "R5 R6");
    end

    // R4: pin changes after capture are ignored
    boot_pin0 = 0; boot_pin1 = 0;
    tick(6);
    chk("R4 mode kept", {30'b0, boot_mode}, 32'h2);

    // R7: request held while unacknowledged
    do_reset();
    boot_pin0 = 1; boot_pin1 = 0;
    tick(4);
    boot_pin0 = 0;
    tick(3);
    chk("R7 req held", {31'b0, fetch_req}, 32'h1);
    chk("R7 addr held", fetch_addr, 32'h0);
    chk("R7 sp untouched", stack_ptr, 32'h0);
    chk("R4 mode during wait", {30'b0, boot_mode}, 32'h1);
    run_fetch(32'h2000_0800, 32'h0800_0401, "R6 after wait");

    // R8: standby exit resamples and refetches
    standby_enter = 1; tick(); standby_enter = 0;
    chk("R8 done cleared", {31'b0, seq_done}, 32'h0);
    boot_pin0 = 1; boot_pin1 = 1;
    tick(2);
    chk("R8 parked mode", {30'b0, boot_mode}, 32'h1);
    standby_exit = 1; tick(); standby_exit = 0;
    tick(3);
    chk("R8 not yet latched", {30'b0, boot_mode}, 32'h1);
    chk("R8 no req yet", {31'b0, fetch_req}, 32'h0);
    tick();
    chk("R8 resampled", {30'b0, boot_mode}, 32'h2);
    run_fetch(32'h2000_0C00, 32'h0800_0501, "R8 refetch");

    // R9: reset mid-count restarts
    do_reset();
    boot_pin0 = 1; boot_pin1 = 0;
    tick(2);
    rst_n = 0; tick(); rst_n = 1;
    tick(3);
    chk("R9 count restarted", {31'b0, fetch_req}, 32'h0);
    chk("R9 mode reset", {30'b0, boot_mode}, 32'h0);
    tick();
    chk("R9 latched", {30'b0, boot_mode}, 32'h1);
    chk("R9 req", {31'b0, fetch_req}, 32'h1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule